// File: doc/BRIEF.md
# Watchdog Reset Gate and Cause Latch

This block sits on the path from a watchdog timer's reset request to the chip's system reset. Three single-bit controls decide whether a request may reach the system. The first is a gate bit whose meaning is fixed at build time: either writing one masks the request, or writing one lets it through. The second is an auto-suppress bit that blocks the request while the processor the watchdog guards is itself held in reset. The third is a run-permit bit that is brought out so the watchdog counter can only count while it is set.

A sticky cause flag records that a forwarded watchdog request took place. System reset does not clear it, so software can read it after the reset that the watchdog caused. Only power-on reset or an explicit write of one clears it. Every control bit comes out of reset in the safe state: the request is blocked, auto-suppress is on and the counter is stopped. Software enables the watchdog by clearing auto-suppress, opening the gate and setting the run-permit bit, and disables it by undoing each of these steps.

Software changes each bit with a masked write. It selects a register and supplies a bit-mask and a bit-value, and only positions set in the mask are updated.

Top module: `wdg_rst_glue`

## Requirements
- R1: On `rst` or `por` every control returns to its safe state: the gate blocks, auto-suppress is 1 and `cnt_en` is 0. `sys_rst_req` is 0 in the cycle after reset, and a watchdog request arriving right after reset does not reach `sys_rst_req`.
- R2: With `MASK_INVERT`=0, gate bit `MASK_BIT` (default 20) of register select 0 blocks the request when it is 1 and passes it when it is 0. Its reset value is 1.
- R3: With `MASK_INVERT`=1, the same bit passes the request when it is 1 and blocks it when it is 0. Its reset value is 0.
- R4: Auto-suppress bit `AD_BIT` (default 20) of register select 1 blocks the request only while `cpu_in_reset` is 1. When it is 0, `cpu_in_reset` has no effect.
- R5: `sys_rst_req` is registered. It equals `wdt_req` AND gate-permits AND NOT (auto-suppress AND `cpu_in_reset`), taken from the previous cycle.
- R6: `cnt_en` follows run-permit bit `CNT_BIT` (default 7) of register select 2, starting in the cycle after the write.
- R7: A write changes a control bit only when its position is set in `cfg_bmask` and `cfg_sel` selects that register. Other bits and other registers keep their values.
- R8: `wdt_cause` becomes 1 on the same edge where `sys_rst_req` rises. It stays 1 through `rst`.
- R9: Writing select 3 with bit `CAUSE_BIT` (default 9) set in both mask and value clears `wdt_cause`. Writing 0 to that bit has no effect. If the gated request is active in the same cycle as the clear, the cause flag stays set.
- R10: `por` clears `wdt_cause`. Writes presented while `rst` or `por` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high (includes watchdog-caused reset) |
| por | input | 1 | Synchronous power-on reset, active high |
| cfg_we | input | 1 | Write strobe for the control registers |
| cfg_sel | input | 2 | Register select: 0 gate, 1 auto-suppress, 2 run-permit, 3 cause |
| cfg_bmask | input | REG_W | Bit positions the write may change |
| cfg_bval | input | REG_W | Values for the positions in the mask |
| wdt_req | input | 1 | Reset request from the watchdog timer |
| cpu_in_reset | input | 1 | Guarded processor is held in reset |
| sys_rst_req | output | 1 | Gated, registered watchdog reset to the system |
| cnt_en | output | 1 | Permission for the watchdog counter to run |
| wdt_cause | output | 1 | Sticky flag: a watchdog reset was forwarded |

## Verification
The bench sweeps all sixteen combinations of gate bit, auto-suppress bit, request and processor reset on two copies of the block, one per mask polarity. This exposes a swapped polarity, an inverted reset value, or suppression applied even when the processor is running. The cause flag is checked across a system reset: if `rst` cleared it, the flag would read 0 when it should still hold. The flag is also checked across a clear that lands while the request is still active: if the clear won that race, the event would be lost. Masked writes whose mask leaves out the target bit, and writes made during reset, must leave the controls untouched. A design that ignored the bit-mask would open the gate or start the counter.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_GATE    = 2'd0,
    SEL_AUTODIS = 2'd1,
    SEL_COUNT   = 2'd2,
    SEL_CAUSE   = 2'd3
  } wdg_sel_e;
endpackage

// File: rtl/wdg_bit_reg.sv
module wdg_bit_reg
  import wdg_pkg::*;
#(
  parameter int       REG_W   = 32,
  parameter int       BIT     = 0,
  parameter wdg_sel_e SEL     = SEL_GATE,
  parameter logic     RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [REG_W-1:0] bmask,
  input  logic [REG_W-1:0] bval,
  output logic             q
);
  logic hit;
  assign hit = we && (sel == SEL) && bmask[BIT];

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (hit) q <= bval[BIT];
  end
endmodule

// File: rtl/wdg_gate.sv
module wdg_gate #(
  parameter bit MASK_INVERT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_q,
  input  logic ad_q,
  input  logic wdt_req,
  input  logic cpu_in_reset,
  output logic permit,
  output logic gated,
  output logic sys_rst_req
);
  generate
    if (MASK_INVERT) begin : g_enable_pol
      assign permit = gate_q;
    end else begin : g_mask_pol
      assign permit = ~gate_q;
    end
  endgenerate

  assign gated = wdt_req & permit & ~(ad_q & cpu_in_reset);

  always_ff @(posedge clk) begin
    if (rst) sys_rst_req <= 1'b0;
    else     sys_rst_req <= gated;
  end
endmodule

// File: rtl/wdg_cause.sv
module wdg_cause
  import wdg_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int CAUSE_BIT = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [REG_W-1:0] bmask,
  input  logic [REG_W-1:0] bval,
  input  logic             gated,
  output logic             cause
);
  logic clr;
  assign clr = we && !rst && (sel == SEL_CAUSE) && bmask[CAUSE_BIT] && bval[CAUSE_BIT];

  always_ff @(posedge clk) begin
    if (por)        cause <= 1'b0;
    else if (gated) cause <= 1'b1;
    else if (clr)   cause <= 1'b0;
  end
endmodule

// File: rtl/wdg_rst_glue.sv
module wdg_rst_glue
  import wdg_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter bit MASK_INVERT = 1'b0,
  parameter int MASK_BIT    = 20,
  parameter int AD_BIT      = 20,
  parameter int CNT_BIT     = 7,
  parameter int CAUSE_BIT   = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [REG_W-1:0] cfg_bmask,
  input  logic [REG_W-1:0] cfg_bval,
  input  logic             wdt_req,
  input  logic             cpu_in_reset,
  output logic             sys_rst_req,
  output logic             cnt_en,
  output logic             wdt_cause
);
  localparam logic GATE_SAFE = MASK_INVERT ? 1'b0 : 1'b1;

  logic any_rst;
  logic gate_q, ad_q, cnt_q;
  logic permit, gated;

  assign any_rst = rst | por;

  wdg_bit_reg #(.REG_W(REG_W), .BIT(MASK_BIT), .SEL(SEL_GATE), .RST_VAL(GATE_SAFE)) u_gate (
    .clk(clk), .rst(any_rst), .we(cfg_we), .sel(cfg_sel),
    .bmask(cfg_bmask), .bval(cfg_bval), .q(gate_q));

  wdg_bit_reg #(.REG_W(REG_W), .BIT(AD_BIT), .SEL(SEL_AUTODIS), .RST_VAL(1'b1)) u_autodis (
    .clk(clk), .rst(any_rst), .we(cfg_we), .sel(cfg_sel),
    .bmask(cfg_bmask), .bval(cfg_bval), .q(ad_q));

  wdg_bit_reg #(.REG_W(REG_W), .BIT(CNT_BIT), .SEL(SEL_COUNT), .RST_VAL(1'b0)) u_count (
    .clk(clk), .rst(any_rst), .we(cfg_we), .sel(cfg_sel),
    .bmask(cfg_bmask), .bval(cfg_bval), .q(cnt_q));

  wdg_gate #(.MASK_INVERT(MASK_INVERT)) u_gating (
    .clk(clk), .rst(any_rst), .gate_q(gate_q), .ad_q(ad_q),
    .wdt_req(wdt_req), .cpu_in_reset(cpu_in_reset),
    .permit(permit), .gated(gated), .sys_rst_req(sys_rst_req));

  wdg_cause #(.REG_W(REG_W), .CAUSE_BIT(CAUSE_BIT)) u_cause (
    .clk(clk), .rst(any_rst), .por(por), .we(cfg_we), .sel(cfg_sel),
    .bmask(cfg_bmask), .bval(cfg_bval), .gated(gated), .cause(wdt_cause));

  assign cnt_en = cnt_q;
endmodule

// File: rtl/wdg_rst_glue_chk.sv
module wdg_rst_glue_chk #(
  parameter int REG_W     = 32,
  parameter int CNT_BIT   = 7,
  parameter int CAUSE_BIT = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             por,
  input logic             cfg_we,
  input logic [1:0]       cfg_sel,
  input logic [REG_W-1:0] cfg_bmask,
  input logic [REG_W-1:0] cfg_bval,
  input logic             wdt_req,
  input logic             cpu_in_reset,
  input logic             permit,
  input logic             ad_q,
  input logic             sys_rst_req,
  input logic             cnt_en,
  input logic             wdt_cause
);
  // R5
  fwd_req_chk: assert property (@(posedge clk) disable iff (rst || por)
    (wdt_req && permit && !(ad_q && cpu_in_reset)) |=> sys_rst_req);

  // R5
  no_req_no_rst_chk: assert property (@(posedge clk) disable iff (rst || por)
    !wdt_req |=> !sys_rst_req);

  // R1
  safe_after_reset_chk: assert property (@(posedge clk)
    (rst || por) |=> (!sys_rst_req && !cnt_en));

  // R8
  cause_with_rst_chk: assert property (@(posedge clk) disable iff (por)
    sys_rst_req |-> wdt_cause);

  // R8
  cause_sticky_chk: assert property (@(posedge clk) disable iff (por)
    (wdt_cause && !(cfg_we && cfg_sel == 2'd3 && cfg_bmask[CAUSE_BIT] && cfg_bval[CAUSE_BIT]))
    |=> wdt_cause);

  // R6
  cnt_write_chk: assert property (@(posedge clk) disable iff (rst || por)
    (cfg_we && cfg_sel == 2'd2 && cfg_bmask[CNT_BIT]) |=> (cnt_en == $past(cfg_bval[CNT_BIT])));
endmodule

bind wdg_rst_glue wdg_rst_glue_chk #(.REG_W(REG_W), .CNT_BIT(CNT_BIT), .CAUSE_BIT(CAUSE_BIT)) u_chk (
  .clk(clk), .rst(rst), .por(por), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_bmask(cfg_bmask), .cfg_bval(cfg_bval), .wdt_req(wdt_req),
  .cpu_in_reset(cpu_in_reset), .permit(permit), .ad_q(ad_q),
  .sys_rst_req(sys_rst_req), .cnt_en(cnt_en), .wdt_cause(wdt_cause));

// File: tb/wdg_rst_glue_test.sv
module wdg_rst_glue_test;
  localparam int W  = 32;
  localparam int MB = 20;
  localparam int AB = 20;
  localparam int CB = 7;
  localparam int SB = 9;

  logic clk = 1'b0;
  logic rst, por, cfg_we, wdt_req, cpu_in_reset;
  logic [1:0]   cfg_sel;
  logic [W-1:0] cfg_bmask, cfg_bval;
  logic sys_a, cnt_a, cause_a;
  logic sys_b, cnt_b, cause_b;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wdg_rst_glue #(.MASK_INVERT(1'b0)) uut (
    .clk(clk), .rst(rst), .por(por), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_bmask(cfg_bmask), .cfg_bval(cfg_bval), .wdt_req(wdt_req),
    .cpu_in_reset(cpu_in_reset), .sys_rst_req(sys_a), .cnt_en(cnt_a), .wdt_cause(cause_a));

  wdg_rst_glue #(.MASK_INVERT(1'b1)) uut_inv (
    .clk(clk), .rst(rst), .por(por), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_bmask(cfg_bmask), .cfg_bval(cfg_bval), .wdt_req(wdt_req),
    .cpu_in_reset(cpu_in_reset), .sys_rst_req(sys_b), .cnt_en(cnt_b), .wdt_cause(cause_b));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] bm, input logic [W-1:0] bv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_bmask = bm; cfg_bval = bv;
    @(negedge clk);
    cfg_we = 1'b0; cfg_bmask = '0; cfg_bval = '0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rst = 1; por = 1; cfg_we = 0; cfg_sel = 0; cfg_bmask = 0; cfg_bval = 0;
    wdt_req = 0; cpu_in_reset = 0;
    wait_n(3);
    por = 0; rst = 0;
    // R1 reset state
    check("R1 sys a", sys_a, 0);   check("R1 sys b", sys_b, 0);
    check("R1 cnt a", cnt_a, 0);   check("R1 cnt b", cnt_b, 0);
    check("R10 cause a", cause_a, 0);
    wdt_req = 1; wait_n(2);
    check("R1 blocked a", sys_a, 0); check("R1 blocked b", sys_b, 0);
    check("R1 no cause", cause_a, 0);
    wdt_req = 0; wait_n(1);

    // R2 R3 R4 R5 R8 R9 sweep
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 2; a++)
        for (int rq = 0; rq < 2; rq++)
          for (int cr = 0; cr < 2; cr++) begin
            logic ea, eb, sup;
            wr(2'd0, W'(1) << MB, W'(m) << MB);
            wr(2'd1, W'(1) << AB, W'(a) << AB);
            wdt_req = rq[0]; cpu_in_reset = cr[0];
            wait_n(2);
            sup = a[0] & cr[0];
            ea = rq[0] & ~m[0] & ~sup;
            eb = rq[0] &  m[0] & ~sup;
            check("R2 R4 R5 gate a", sys_a, ea);
            check("R3 R4 R5 gate b", sys_b, eb);
            check("R8 cause a", cause_a, ea);
            check("R8 cause b", cause_b, eb);
            wdt_req = 0; wait_n(2);
            wr(2'd3, W'(1) << SB, W'(1) << SB);
            wait_n(1);
            check("R9 clear a", cause_a, 0);
            check("R9 clear b", cause_b, 0);
          end
    cpu_in_reset = 0;

    // R6 counter permit
    wr(2'd2, W'(1) << CB, W'(1) << CB);
    check("R6 cnt set", cnt_a, 1); check("R6 cnt set b", cnt_b, 1);
    wr(2'd2, W'(1) << CB, 0);
    check("R6 cnt clear", cnt_a, 0);

    // R7 masked writes: a open (0), ad off already from sweep end = 1? set explicitly
    wr(2'd0, W'(1) << MB, 0);
    wr(2'd1, W'(1) << AB, 0);
    wr(2'd0, ~(W'(1) << MB), '1);
    wr(2'd2, ~(W'(1) << CB), '1);
    wr(2'd1, '1, '1);              // other register, also sets ad
    cpu_in_reset = 0; wdt_req = 1; wait_n(2);
    check("R7 gate a unchanged", sys_a, 1);
    check("R7 gate b unchanged", sys_b, 0);
    check("R7 cnt unchanged", cnt_a, 0);
    check("R8 cause set", cause_a, 1);

    // R9 set wins over clear while request active
    wr(2'd3, W'(1) << SB, W'(1) << SB);
    check("R9 set wins", cause_a, 1);
    wdt_req = 0; wait_n(2);
    // R9 writing zero / unmasked does nothing
    wr(2'd3, W'(1) << SB, 0);
    check("R9 write zero", cause_a, 1);
    wr(2'd3, ~(W'(1) << SB), '1);
    check("R9 unmasked", cause_a, 1);

    // R8 sticky across system reset; R1 controls back to safe
    wr(2'd2, W'(1) << CB, W'(1) << CB);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    check("R8 sticky rst", cause_a, 1);
    check("R1 cnt after rst", cnt_a, 0);
    wdt_req = 1; wait_n(2);
    check("R1 masked after rst", sys_a, 0);
    wdt_req = 0;

    // R10 por clears cause; writes during reset ignored
    @(negedge clk); por = 1; @(negedge clk); por = 0;
    check("R10 por clears", cause_a, 0);
    rst = 1;
    wr(2'd2, W'(1) << CB, W'(1) << CB);
    wr(2'd0, W'(1) << MB, 0);
    rst = 0; wait_n(1);
    check("R10 cnt ignored", cnt_a, 0);
    wdt_req = 1; wait_n(2);
    check("R10 gate ignored", sys_a, 0);
    wdt_req = 0; wait_n(1);

    summary();
  end
endmodule